// File: doc/BRIEF.md
# Fully Associative Read Cache with Rotating Victim Pointer

This block is a read-only cache of 64 lines, each 32 bytes long, sitting between a processor read port and a slower memory. Any block of the 32-bit byte address space may be placed in any line. On every lookup, the stored tag of every line is compared with the request tag at the same time. A hit returns the addressed 32-bit word on the cycle after the request is accepted. A miss fetches the whole line from memory over a request/response fill interface, then answers the processor.

Replacement uses a single victim pointer instead of a true usage history. The pointer names the next line to overwrite. It steps forward only when the line it names is used, either by a hit or by the completion of a fill into that line. Heavily used lines therefore tend to push the pointer past themselves, which gives a cheap approximation of least-recently-used.

Three handshakes are valid/ready:
- **Request port:** a request is taken only on a cycle with both `req_valid` and `req_ready` high. `req_ready` stays low from acceptance until the answer has been given.
- **Fill request:** the requester holds `fill_req_valid` and the line address steady until `fill_req_ready` is seen.
- **Fill data:** words move only on cycles where `fill_valid` and `fill_ready` are both high, so memory can stall at will.

The response (`resp_valid`, `resp_data`) is a one-cycle pulse with no back-pressure. The processor must take it when it appears.

Top module: `fac_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `fill_req_valid` and `fill_ready` are 0. No line is valid, so the first access to any address, including one cached before the reset, misses.
- R2: Address bits [31:5] form the tag and bits [4:2] select the word in the line. Bits [1:0] are ignored. Any address in a cached 32-byte block hits, and `resp_data` is the word at the address with bits [1:0] cleared.
- R3: An accepted request that hits raises `resp_valid` for exactly one cycle, on the cycle after acceptance, and issues no fill request.
- R4: An accepted request that misses leaves `resp_valid` low on the cycle after acceptance. On the cycle after that, it raises `fill_req_valid` with `fill_req_addr` equal to the request address with bits [4:0] cleared. Both are held unchanged until `fill_req_ready` is 1.
- R5: After the fill request is taken, `fill_ready` is 1 until exactly eight words have been accepted, and 0 otherwise. The k-th accepted word (k = 0..7) becomes the word at byte offset 4k of the line. Cycles with `fill_valid` low transfer nothing.
- R6: `req_ready` is 0 from the cycle after acceptance through the response cycle, and 1 again on the following cycle.
- R7: On the cycle after the eighth fill word is accepted, `resp_valid` is 1 and `resp_data` carries the requested word of the new line.
- R8: The line overwritten on a miss is the one the victim pointer names. The pointer is 0 after reset.
- R9: A hit on the line named by the pointer advances the pointer by one. A hit on any other line leaves it unchanged.
- R10: A completed fill advances the pointer by one, and the pointer wraps from 63 to 0. After 64 distinct fills following reset, the next miss overwrites the first line filled.
- R11: Any 64 distinct blocks can be resident at once, whatever their address bits, and a block hits only while its line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Cache can take a request |
| req_addr | input | 32 | Byte address of the read |
| resp_valid | output | 1 | One-cycle pulse: read data valid |
| resp_data | output | 32 | Returned word |
| fill_req_valid | output | 1 | Line fetch requested |
| fill_req_ready | input | 1 | Memory takes the line fetch |
| fill_req_addr | output | 32 | Line-aligned address to fetch |
| fill_valid | input | 1 | Memory presents a fill word |
| fill_ready | output | 1 | Cache accepts a fill word |
| fill_data | input | 32 | Fill word, in ascending address order |

## Verification
A wrong victim pointer does not show up immediately. It appears only on a later miss, as the loss of a line that should have stayed. The bench therefore keeps a model of the resident blocks and the pointer, and checks the hit-or-miss outcome of every access, including the accesses made after the pointer wraps. Corrupted tags or valid bits show up on the very next lookup as a false hit, or as a fill request where a hit was due. A wrong fill word position shows up as bad `resp_data` on either the fill response or a later hit to the same line.

// File: rtl/fac_pkg.sv
package fac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FREQ,
    ST_FDATA,
    ST_RESP
  } fac_state_e;
endpackage

// File: rtl/fac_tag_match.sv
module fac_tag_match #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             inv_en,
  input  logic             set_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_line
    always_ff @(posedge clk) begin
      if (set_en && wr_idx == IDX_W'(gi)) tag_q[gi] <= wr_tag;
    end
    assign match[gi] = vld_q[gi] && (tag_q[gi] == look_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[wr_idx] <= 1'b0;
      if (set_en) vld_q[wr_idx] <= 1'b1;
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign hit = |match;

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R11

  AST_SET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> vld_q[$past(wr_idx)]); // R11
endmodule

// File: rtl/fac_victim_ptr.sv
module fac_victim_ptr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |->
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R10

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr)); // R9
endmodule

// File: rtl/fac_line_store.sv
module fac_line_store #(
  parameter int ENTRIES = 64,
  parameter int WORDS   = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int WSEL_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_ent,
  input  logic [WSEL_W-1:0] w_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  r_ent,
  input  logic [WSEL_W-1:0] r_word,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = ENTRIES * WORDS;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_ent, w_word}] <= wdata;
  end

  assign rdata = mem[{r_ent, r_word}];
endmodule

// File: rtl/fac_cache.sv
module fac_cache
  import fac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  fac_state_e              state_q, state_d;
  logic [ADDR_W-1:BYTE_W]  addr_q;
  logic [IDX_W-1:0]        vic_q;
  logic [WSEL_W-1:0]       beat_q;

  logic [TAG_W-1:0]  look_tag;
  logic [WSEL_W-1:0] word_sel;
  logic              hit, look_hit, look_miss;
  logic [IDX_W-1:0]  hit_idx, ptr, tm_idx, rd_ent;
  logic              accept, beat_fire, last_beat, advance;
  logic [DATA_W-1:0] rdata;
  logic              unused_byte;

  assign unused_byte = ^req_addr[BYTE_W-1:0];

  assign look_tag  = addr_q[ADDR_W-1:OFF_W];
  assign word_sel  = addr_q[OFF_W-1:BYTE_W];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_hit  = (state_q == ST_LOOK) && hit;
  assign look_miss = (state_q == ST_LOOK) && !hit;
  assign fill_ready = (state_q == ST_FDATA);
  assign beat_fire = fill_ready && fill_valid;
  assign last_beat = beat_fire && (beat_q == LAST_BEAT);
  assign advance   = (look_hit && (hit_idx == ptr)) || last_beat;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_LOOK;
      ST_LOOK:  state_d = hit ? ST_IDLE : ST_FREQ;
      ST_FREQ:  if (fill_req_ready) state_d = ST_FDATA;
      ST_FDATA: if (last_beat) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      vic_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) addr_q <= req_addr[ADDR_W-1:BYTE_W];
      if (look_miss) begin
        vic_q  <= ptr;
        beat_q <= '0;
      end else if (beat_fire) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign tm_idx = (state_q == ST_LOOK) ? ptr : vic_q;

  fac_tag_match #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_tag (look_tag),
    .inv_en   (look_miss),
    .set_en   (last_beat),
    .wr_idx   (tm_idx),
    .wr_tag   (look_tag),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  fac_victim_ptr #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .ptr     (ptr)
  );

  assign rd_ent = (state_q == ST_RESP) ? vic_q : hit_idx;

  fac_line_store #(
    .ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk    (clk),
    .we     (beat_fire),
    .w_ent  (vic_q),
    .w_word (beat_q),
    .wdata  (fill_data),
    .r_ent  (rd_ent),
    .r_word (word_sel),
    .rdata  (rdata)
  );

  assign resp_valid     = look_hit || (state_q == ST_RESP);
  assign resp_data      = rdata;
  assign fill_req_valid = (state_q == ST_FREQ);
  assign fill_req_addr  = {look_tag, {OFF_W{1'b0}}};

  AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R3

  AST_REQ_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> req_ready); // R6

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=>
      (fill_req_valid && $stable(fill_req_addr))); // R4

  AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    look_miss |=> fill_req_valid); // R4

  AST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> (vic_q == ptr)); // R8

  AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> (resp_valid && !fill_ready)); // R7
endmodule

// File: tb/sim_fac_cache.sv
`timescale 1ns/1ps
module sim_fac_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic        fill_req_valid;
  logic        fill_req_ready = 1'b0;
  logic [31:0] fill_req_addr;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [31:0] fill_data = '0;

  int checks = 0;
  int fails  = 0;
  int stall_ctr = 0;

  logic [26:0] m_tag [64];
  bit          m_vld [64];
  int          m_ptr;

  // {expected hit, address}
  localparam logic [32:0] VEC [10] = '{
    {1'b0, 32'h0000_0000},  // cold miss -> line 0
    {1'b1, 32'h0000_0004},
    {1'b1, 32'h0000_001C},
    {1'b0, 32'h0000_0020},  // -> line 1
    {1'b0, 32'h1234_5678},  // -> line 2
    {1'b1, 32'h1234_5660},
    {1'b1, 32'h0000_0024},
    {1'b0, 32'hFFFF_FFFC},  // -> line 3
    {1'b1, 32'hFFFF_FFE0},
    {1'b1, 32'h0000_0013}   // byte bits ignored
  };

  always #2 clk = ~clk;

  fac_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data)
  );

  function automatic logic [31:0] fdata(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h2468_ACE0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endtask

  function automatic int m_find(input logic [31:0] a);
    for (int i = 0; i < 64; i++)
      if (m_vld[i] && m_tag[i] == a[31:5]) return i;
    return -1;
  endfunction

  task automatic do_access(input logic [31:0] a, input string req, output bit got_hit);
    int  ei;
    bit  eh;
    int  k;
    logic [31:0] line;
    ei = m_find(a);
    eh = (ei >= 0);
    line = {a[31:5], 5'b0};
    @(negedge clk);
    chk(req_ready == 1'b1, "R6", "req_ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    got_hit = resp_valid;
    chk(got_hit == eh, req, "hit flag", 32'(got_hit), 32'(eh));
    chk(req_ready == 1'b0, "R6", "req_ready busy", 32'(req_ready), 32'd0);
    if (got_hit) begin
      chk(resp_data == fdata(a), "R2", "hit data", resp_data, fdata(a));
      chk(fill_req_valid == 1'b0, "R3", "no fill on hit", 32'(fill_req_valid), 32'd0);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R3", "single pulse", 32'(resp_valid), 32'd0);
      if (ei == m_ptr) m_ptr = (m_ptr + 1) % 64;
    end else begin
      chk(fill_req_valid == 1'b0, "R4", "fill req timing", 32'(fill_req_valid), 32'd0);
      @(negedge clk);
      chk(fill_req_valid == 1'b1, "R4", "fill req raised", 32'(fill_req_valid), 32'd1);
      chk(fill_req_addr == line, "R4", "fill addr", fill_req_addr, line);
      @(negedge clk);
      chk(fill_req_valid == 1'b1 && fill_req_addr == line, "R4", "fill req held",
          fill_req_addr, line);
      chk(fill_ready == 1'b0, "R5", "no data before grant", 32'(fill_ready), 32'd0);
      fill_req_ready = 1'b1;
      @(negedge clk);
      fill_req_ready = 1'b0;
      k = 0;
      while (k < 8) begin
        stall_ctr++;
        fill_valid = (stall_ctr % 3) != 0;
        fill_data  = fdata(line + 32'(4 * k));
        chk(fill_ready == 1'b1, "R5", "fill_ready in fill", 32'(fill_ready), 32'd1);
        chk(req_ready == 1'b0, "R6", "req_ready during fill", 32'(req_ready), 32'd0);
        @(negedge clk);
        if (fill_valid) k++;
      end
      fill_valid = 1'b0;
      chk(resp_valid == 1'b1, "R7", "fill resp valid", 32'(resp_valid), 32'd1);
      chk(resp_data == fdata(a), "R7", "fill resp data", resp_data, fdata(a));
      chk(fill_ready == 1'b0, "R5", "fill_ready after 8", 32'(fill_ready), 32'd0);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R7", "resp single pulse", 32'(resp_valid), 32'd0);
      m_tag[m_ptr] = a[31:5];
      m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % 64;
    end
  endtask

  function automatic logic [31:0] lad(input int i);
    return (32'(i) << 12) | 32'h0000_0100;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit h;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
    chk(fill_req_valid == 1'b0, "R1", "fill_req in reset", 32'(fill_req_valid), 32'd0);
    chk(fill_ready == 1'b0, "R1", "fill_ready in reset", 32'(fill_ready), 32'd0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < 10; v++) begin
      do_access(VEC[v][31:0], "R2", h);
      chk(h == VEC[v][32], "R8", "table hit flag", 32'(h), 32'(VEC[v][32]));
    end

    // R1: reset mid-run forgets everything
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    do_access(32'h0000_0000, "R1", h);
    chk(h == 1'b0, "R1", "miss after reset", 32'(h), 32'd0);

    // R11: 64 blocks sharing low address bits all resident
    for (int i = 1; i < 64; i++) do_access(lad(i), "R11", h);
    for (int i = 1; i < 64; i++) begin
      do_access(lad(i), "R11", h);
      chk(h == 1'b1, "R11", "resident block", 32'(h), 32'd1);
    end
    // pointer has wrapped to 0: hit on line 0 advances it (R9, R10)
    do_access(32'h0000_0008, "R9", h);
    chk(h == 1'b1, "R9", "line 0 hit", 32'(h), 32'd1);
    do_access(32'hABCD_E000, "R10", h);      // evicts line 1
    do_access(lad(1), "R10", h);
    chk(h == 1'b0, "R10", "evicted after wrap", 32'(h), 32'd0);
    do_access(lad(3), "R9", h);               // pointer line 3
    do_access(lad(5), "R9", h);               // not pointer
    do_access(32'h5555_5540, "R8", h);       // evicts line 4
    do_access(lad(4), "R8", h);
    chk(h == 1'b0, "R8", "victim evicted", 32'(h), 32'd0);
    do_access(lad(6), "R9", h);
    do_access(lad(5), "R9", h);
    do_access(32'h0000_0010, "R11", h);
    chk(h == 1'b1, "R11", "line 0 kept", 32'(h), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule